// File: doc/BRIEF.md
# ADC SPI command and register engine

This block is the host side of a serial link to a multichannel delta-sigma converter. A local controller issues one request at a time. The request is one of four kinds: a bare one-byte command, a register read, a register write, or a read of a sample frame. The engine frames each request with chip-select, shifts the bytes out in SPI mode 1, and hands every byte it receives back on a one-cycle strobed byte output.

Register accesses put the 5-bit register address into the opcode, and a don't-care zero byte always follows the opcode. The converter needs time to decode such a command, so the engine holds the clock idle, with chip-select still asserted, for a programmed number of system-clock cycles. For a read, this wait comes before the response byte is clocked in. For a write, it comes before chip-select is released. A frame read has no such wait: the opcode is followed at once by the requested number of response bytes.

Top module: `adc_spi_engine`

## Requirements
- R1: During and just after reset, spi_cs_n is 1, spi_sclk is 0, and busy, done and rx_valid are 0.
- R2: A command request (req_kind 0) sends exactly one byte, req_opcode, in its own chip-select frame, and produces no rx_valid.
- R3: A register read (req_kind 1) sends 0x20 OR req_addr, then 0x00, then clocks in one byte. That byte appears once on rx_data with rx_valid.
- R4: A register write (req_kind 2) sends 0x40 OR req_addr, then 0x00, then req_wdata, and produces no rx_valid.
- R5: After the command bytes of a register read or write, spi_sclk stays low with spi_cs_n low for at least DECODE_CYCLES system-clock cycles. For a read, this wait ends before the response byte. For a write, it ends before chip-select is released.
- R6: A frame read (req_kind 3) sends 0x12 and then clocks in req_len bytes (1 to MAX_FRAME). The gap before the first response byte is an ordinary inter-byte gap, shorter than DECODE_CYCLES. Each byte gets a one-cycle rx_valid pulse, in the order received.
- R7: busy is high for the whole time chip-select is asserted. A req_valid seen while busy is high is ignored and starts no frame.
- R8: SPI mode 1 applies. spi_sclk idles low. spi_mosi changes only on a rising spi_sclk edge. spi_miso is sampled on the falling edge. Every byte is sent and received most significant bit first.
- R9: done is a one-cycle pulse. It is raised in the same cycle that spi_cs_n returns high, once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_kind | input | 2 | 0 command, 1 register read, 2 register write, 3 frame read |
| req_opcode | input | 8 | Opcode byte for a command request |
| req_addr | input | 5 | Register address for a read or write |
| req_wdata | input | 8 | Data byte for a register write |
| req_len | input | LW | Number of bytes in a frame read |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Suppose the byte index or the transmit/receive split goes wrong. The port symptom is then a wrong byte on spi_mosi, a missing or extra rx_valid, or a frame of the wrong length, and it shows within the frame in which the fault occurs. A wrong decode-timer load or a skipped decode state shows as a short gap. The bench measures that gap in system cycles at the byte boundary of the same frame. A broken busy or done path shows as a second frame after an ignored request, or as a done pulse that does not line up with chip-select release. Both show at the end of the current request.

// File: rtl/adc_spi_engine.sv
module adc_spi_engine #(
  parameter int CLK_HALF      = 2,
  parameter int DECODE_CYCLES = 8,
  parameter int MAX_FRAME     = 32,
  localparam int LW = $clog2(MAX_FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [7:0]    req_opcode,
  input  logic [4:0]    req_addr,
  input  logic [7:0]    req_wdata,
  input  logic [LW-1:0] req_len,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs_n
);
  localparam int CW = $clog2(CLK_HALF) + 1;
  localparam int DW = $clog2(DECODE_CYCLES) + 1;
  localparam int BW = $clog2(MAX_FRAME + 4);
  localparam logic [CW-1:0] HALF_M1 = CW'(CLK_HALF - 1);
  localparam logic [DW-1:0] DEC_M1  = DW'(DECODE_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_DECODE, S_END} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [DW-1:0] tmr;
  logic          ph, dec_en;
  logic [2:0]    bitc;
  logic [BW-1:0] bidx, n_tx, n_tot;
  logic [7:0]    sh, rsh, wd;

  wire [BW-1:0] nxt     = bidx + 1'b1;
  wire          last_tx = (nxt == n_tx);
  wire          last    = (nxt == n_tot);
  wire [7:0]    nbyte   = (nxt == BW'(2) && n_tx == BW'(3)) ? wd : 8'h00;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      tmr      <= '0;
      ph       <= 1'b0;
      dec_en   <= 1'b0;
      bitc     <= '0;
      bidx     <= '0;
      n_tx     <= '0;
      n_tot    <= '0;
      sh       <= '0;
      rsh      <= '0;
      wd       <= '0;
      done     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      spi_sclk <= 1'b0;
      spi_mosi <= 1'b0;
      spi_cs_n <= 1'b1;
    end else begin
      done     <= 1'b0;
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          spi_cs_n <= 1'b0;
          st       <= S_SETUP;
          cnt      <= HALF_M1;
          bidx     <= '0;
          bitc     <= '0;
          ph       <= 1'b0;
          wd       <= req_wdata;
          case (req_kind)
            2'd0: begin sh <= req_opcode;             n_tx <= BW'(1); n_tot <= BW'(1); dec_en <= 1'b0; end
            2'd1: begin sh <= {3'b001, req_addr};     n_tx <= BW'(2); n_tot <= BW'(3); dec_en <= 1'b1; end
            2'd2: begin sh <= {3'b010, req_addr};     n_tx <= BW'(3); n_tot <= BW'(3); dec_en <= 1'b1; end
            default: begin sh <= 8'h12;               n_tx <= BW'(1); n_tot <= BW'(1) + BW'(req_len); dec_en <= 1'b0; end
          endcase
        end
        S_SETUP: begin
          if (cnt == '0) st <= S_SHIFT;
          else cnt <= cnt - 1'b1;
        end
        S_SHIFT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!ph) begin
            spi_sclk <= 1'b1;
            spi_mosi <= sh[7];
            sh       <= {sh[6:0], 1'b0};
            ph       <= 1'b1;
            cnt      <= HALF_M1;
          end else begin
            spi_sclk <= 1'b0;
            ph       <= 1'b0;
            cnt      <= HALF_M1;
            rsh      <= {rsh[6:0], spi_miso};
            bitc     <= bitc + 1'b1;
            if (bitc == 3'd7) begin
              if (bidx >= n_tx) begin
                rx_data  <= {rsh[6:0], spi_miso};
                rx_valid <= 1'b1;
              end
              bidx <= nxt;
              sh   <= nbyte;
              if (last_tx && dec_en) begin
                st  <= S_DECODE;
                tmr <= DEC_M1;
              end else if (last) st <= S_END;
            end
          end
        end
        S_DECODE: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (bidx == n_tot) begin
            st  <= S_END;
            cnt <= HALF_M1;
          end else begin
            st  <= S_SHIFT;
            cnt <= '0;
          end
        end
        S_END: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            spi_cs_n <= 1'b1;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_spi_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rx_valid,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic spi_cs_n
);
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> $rose(spi_sclk));
  p_done_at_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && $past(!spi_cs_n)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
  p_rx_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_rx_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !spi_cs_n);
endmodule

bind adc_spi_engine adc_spi_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rx_valid(rx_valid),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/tb_adc_spi_engine.sv
`timescale 1ns/1ps
module tb_adc_spi_engine;
  localparam int HALF = 2, DEC = 20, MAXF = 32, LW = $clog2(MAXF + 1);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [7:0] req_opcode = 0, req_wdata = 0;
  logic [4:0] req_addr = 0;
  logic [LW-1:0] req_len = 0;
  logic busy, done, rx_valid, spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 0;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  adc_spi_engine #(.CLK_HALF(HALF), .DECODE_CYCLES(DEC), .MAX_FRAME(MAXF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_len(req_len), .busy(busy), .done(done), .rx_data(rx_data),
    .rx_valid(rx_valid), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [7:0] slave_b [0:39];
  logic [7:0] mosi_b [0:39];
  logic [7:0] rxb [0:39];
  int gap [0:39];
  int nmosi, nrx, tail, frames, dones, rises, falls, since_fall;
  bit done_at_release, busy_in_frame_ok;
  logic prev_sclk = 0, prev_cs = 1;
  logic [7:0] msh;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    since_fall++;
    if (!spi_cs_n && prev_cs) begin
      frames++; nmosi = 0; nrx = 0; rises = 0; falls = 0; since_fall = 0;
      busy_in_frame_ok = 1;
      for (int i = 0; i < 40; i++) gap[i] = -1;
    end
    if (!spi_cs_n && !busy) busy_in_frame_ok = 0;
    if (spi_sclk && !prev_sclk) begin
      if (rises % 8 == 0 && rises > 0) gap[rises / 8] = since_fall;
      spi_miso = slave_b[rises / 8][7 - (rises % 8)];
      rises++;
    end
    if (!spi_sclk && prev_sclk) begin
      msh = {msh[6:0], spi_mosi};
      falls++;
      since_fall = 0;
      if (falls % 8 == 0) begin mosi_b[nmosi] = msh; nmosi++; end
    end
    if (spi_cs_n && !prev_cs) begin tail = since_fall; done_at_release = done; end
    if (rx_valid) begin rxb[nrx] = rx_data; nrx++; end
    if (done) dones++;
    prev_sclk = spi_sclk;
    prev_cs = spi_cs_n;
  end

  task automatic seed_slave(input logic [7:0] s);
    for (int k = 0; k < 40; k++) slave_b[k] = s ^ 8'(k * 37);
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] op, input logic [4:0] a,
                       input logic [7:0] w, input int len);
    int d0, t;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_opcode = op; req_addr = a; req_wdata = w;
    req_len = LW'(len);
    d0 = dones;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (dones == d0 && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", int'(spi_cs_n), 1);
    chk("R1 sclk", int'(spi_sclk), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done/rx_valid", int'({done, rx_valid}), 0);
  endtask

  task automatic t_cmd(input logic [7:0] op);
    int f0 = frames;
    seed_slave(8'h3C);
    issue(2'd0, op, 5'd0, 8'h00, 0);
    chk("R2 frames", frames - f0, 1);
    chk("R2 byte count", nmosi, 1);
    chk("R2 opcode", int'(mosi_b[0]), int'(op));
    chk("R2 no rx", nrx, 0);
    chk("R9 done at release", int'(done_at_release), 1);
  endtask

  task automatic t_rreg(input logic [4:0] a, input logic [7:0] seed);
    seed_slave(seed);
    issue(2'd1, 8'h00, a, 8'hFF, 0);
    chk("R3 byte count", nmosi, 3);
    chk("R3 opcode", int'(mosi_b[0]), int'(8'h20 | {3'b000, a}));
    chk("R3 pad byte", int'(mosi_b[1]), 0);
    chk("R3 rx count", nrx, 1);
    chk("R3 rx byte R8 msb first", int'(rxb[0]), int'(slave_b[2]));
    chk("R5 read decode wait", int'(gap[2] >= DEC), 1);
    chk("R7 busy in frame", int'(busy_in_frame_ok), 1);
  endtask

  task automatic t_wreg(input logic [4:0] a, input logic [7:0] w);
    seed_slave(8'h55);
    issue(2'd2, 8'h00, a, w, 0);
    chk("R4 byte count", nmosi, 3);
    chk("R4 opcode", int'(mosi_b[0]), int'(8'h40 | {3'b000, a}));
    chk("R4 pad byte", int'(mosi_b[1]), 0);
    chk("R4 data byte", int'(mosi_b[2]), int'(w));
    chk("R4 no rx", nrx, 0);
    chk("R5 write decode wait", int'(tail >= DEC), 1);
    chk("R5 plain gap", int'(gap[1] < DEC), 1);
  endtask

  task automatic t_data(input int len, input logic [7:0] seed);
    int bad = 0;
    seed_slave(seed);
    issue(2'd3, 8'h00, 5'd0, 8'h00, len);
    chk("R6 opcode", int'(mosi_b[0]), 8'h12);
    chk("R6 rx count", nrx, len);
    for (int k = 0; k < len; k++) if (rxb[k] != slave_b[1 + k]) bad++;
    chk("R6 rx order", bad, 0);
    chk("R6 no decode wait", int'(gap[1] < DEC), 1);
    chk("R6 sclk edges", rises, 8 * (len + 1));
  endtask

  task automatic t_ignore();
    int f0, d0, t;
    seed_slave(8'h99);
    f0 = frames; d0 = dones;
    @(negedge clk);
    req_valid = 1; req_kind = 2'd3; req_len = LW'(4);
    @(negedge clk);
    req_kind = 2'd0; req_opcode = 8'h06;
    repeat (20) @(negedge clk);
    chk("R7 busy while active", int'(busy), 1);
    req_valid = 0;
    t = 0;
    while (dones == d0 && t < 5000) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    chk("R7 ignored request", frames - f0, 1);
    chk("R7 idle after", int'({busy, spi_cs_n}), 1);
    chk("R9 one done", dones - d0, 1);
    chk("R6 rx count in ignore test", nrx, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_cmd(8'h0A);
    t_cmd(8'h1A);
    t_rreg(5'h05, 8'hA7);
    t_rreg(5'h1F, 8'h0F);
    t_wreg(5'h01, 8'hA5);
    t_wreg(5'h1E, 8'h3C);
    t_data(1, 8'h81);
    t_data(3, 8'h5A);
    t_data(MAXF, 8'hC3);
    t_ignore();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule